// File: doc/BRIEF.md
# Inbound Address Decode Windows

This block sits between the receive side of a serial interconnect port and an internal memory bus. Each inbound memory address is first tested against one aperture, the range the port exposes to its link partner. An address inside the open aperture is then compared with a set of decode windows. Each window carries a size, a 64 KB-aligned base, a remap value, a target identifier and an attribute byte. The first window that matches supplies the target, the attribute and the translated address. An address that matches no window, or that falls outside the aperture, is reported as a miss.

Software programs the aperture and the windows through a plain register port: a write strobe with address and data, and a read strobe whose data returns on the next clock. Every register clears on reset, so the block starts with the aperture and every window closed. Lookups are combinational over the current register contents and leave through one output register, so each result arrives one clock after its request.

Top module: `inb_win_decoder`

## Requirements
- R1: After reset every register reads back as zero and every lookup reports a miss.
- R2: Only defined fields are stored. A window control keeps bits 31:16, 15:8, 7:4 and 0. Window base, window remap and aperture low base keep bits 31:16. Aperture control keeps bits 31:16 and 0. Aperture high base keeps all 32 bits. All other bits read as zero. Read data appears on the clock after the read strobe and holds while no read is strobed.
- R3: Window i below the last sits at byte offset 0x20+16*i, with control at +0x0, base at +0x4 and remap at +0xC. The last window (index 5 by default) sits at 0x80/0x84/0x8C. Aperture control is at 0x04, low base at 0x10 and high base at 0x14. Any other offset, including 0x00, 0x08, +0x8 inside a window and the skipped slot 0x70, reads zero.
- R4: A lookup can hit only when the aperture is enabled (control bit 0), the high base is zero, and addr[31:16] & ~size equals lowbase[31:16] & ~size, where size is aperture control bits 31:16. Otherwise the lookup misses.
- R5: Inside the aperture, a window matches when its control bit 0 is set and addr[31:16] & ~size equals base[31:16] & ~size, where size is control bits 31:16 (size minus one, in 64 KB units). A disabled window never matches.
- R6: When several windows match, the one with the lowest index is used.
- R7: On a hit, the target output equals control bits 7:4 of the selected window and the attribute output equals its bits 15:8.
- R8: On a hit with remap bits 31:16 equal to zero, the address passes through unchanged. Otherwise output bits 31:16 are (addr & size) | (remap & ~size). Bits 15:0 always pass through.
- R9: A lookup presented with the valid strobe produces its valid, hit and miss outputs on the next clock. Valid with exactly one of hit or miss set, or all three low when no lookup was presented.
- R10: On a miss, the target, attribute and address outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid one clock after reg_rd |
| in_valid | input | 1 | Inbound address valid |
| in_addr | input | 32 | Inbound address |
| out_valid | output | 1 | Lookup result valid |
| out_hit | output | 1 | Lookup matched a window |
| out_miss | output | 1 | Lookup matched nothing |
| out_target | output | 4 | Target identifier of the selected window |
| out_attr | output | 8 | Attribute byte of the selected window |
| out_addr | output | 32 | Translated address |

## Verification
Lookup results, including valid, hit, miss, target, attribute and address, are due exactly one clock after the request. Register read data is due one clock after the read strobe. A register write affects lookups presented from the following clock on. The bench drives every input on the falling edge and samples on the next falling edge, so each sample sees the output register loaded at the one rising edge in between. Lookups are streamed one per clock, with every result checked in the half cycle before the next request takes effect.

// File: rtl/inb_win_pkg.sv
package inb_win_pkg;

  localparam int PAGE_W = 16;

  localparam int AP_CTRL_OFF   = 'h04;
  localparam int AP_LO_OFF     = 'h10;
  localparam int AP_HI_OFF     = 'h14;
  localparam int WIN_FIRST_OFF = 'h20;
  localparam int WIN_STRIDE    = 16;
  localparam int WIN_CTRL_REL  = 'h0;
  localparam int WIN_BASE_REL  = 'h4;
  localparam int WIN_REMAP_REL = 'hC;

  typedef struct packed {
    logic [PAGE_W-1:0] size_m1;
    logic [7:0]        attr;
    logic [3:0]        target;
    logic              en;
  } win_ctrl_t;

  function automatic win_ctrl_t word_to_ctrl(input logic [31:0] w);
    win_ctrl_t c;
    c.size_m1 = w[31:16];
    c.attr    = w[15:8];
    c.target  = w[7:4];
    c.en      = w[0];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_to_word(input win_ctrl_t c);
    return {c.size_m1, c.attr, c.target, 3'b000, c.en};
  endfunction

endpackage

// File: rtl/inb_win_regs.sv
module inb_win_regs
  import inb_win_pkg::*;
#(
  parameter int NUM_WIN = 6,
  parameter int REG_AW  = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic                            rd_en,
  input  logic [REG_AW-1:0]               addr,
  input  logic [31:0]                     wdata,
  output logic [31:0]                     rdata,
  output win_ctrl_t [NUM_WIN-1:0]         win_ctrl,
  output logic [NUM_WIN-1:0][PAGE_W-1:0]  win_base,
  output logic [NUM_WIN-1:0][PAGE_W-1:0]  win_remap,
  output logic                            ap_en,
  output logic [PAGE_W-1:0]               ap_size,
  output logic [PAGE_W-1:0]               ap_base,
  output logic [31:0]                     ap_base_hi
);

  localparam int LAST_OFF = WIN_FIRST_OFF + NUM_WIN * WIN_STRIDE;

  function automatic int win_off(input int i);
    return (i == NUM_WIN - 1) ? LAST_OFF : WIN_FIRST_OFF + i * WIN_STRIDE;
  endfunction

  // aperture registers
  logic              ap_en_q;
  logic [PAGE_W-1:0] ap_size_q;
  logic [PAGE_W-1:0] ap_base_q;
  logic [31:0]       ap_hi_q;

  logic ap_ctrl_we, ap_lo_we, ap_hi_we;
  assign ap_ctrl_we = wr_en && (addr == REG_AW'(AP_CTRL_OFF));
  assign ap_lo_we   = wr_en && (addr == REG_AW'(AP_LO_OFF));
  assign ap_hi_we   = wr_en && (addr == REG_AW'(AP_HI_OFF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ap_en_q   <= 1'b0;
      ap_size_q <= '0;
    end else if (ap_ctrl_we) begin
      ap_en_q   <= wdata[0];
      ap_size_q <= wdata[31:16];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ap_base_q <= '0;
    else if (ap_lo_we) ap_base_q <= wdata[31:16];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ap_hi_q <= '0;
    else if (ap_hi_we) ap_hi_q <= wdata;
  end

  assign ap_en      = ap_en_q;
  assign ap_size    = ap_size_q;
  assign ap_base    = ap_base_q;
  assign ap_base_hi = ap_hi_q;

  // window register sets
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    localparam int OFF = win_off(g);

    win_ctrl_t         ctrl_q;
    logic [PAGE_W-1:0] base_q;
    logic [PAGE_W-1:0] remap_q;
    logic              ctrl_we, base_we, remap_we;

    assign ctrl_we  = wr_en && (addr == REG_AW'(OFF + WIN_CTRL_REL));
    assign base_we  = wr_en && (addr == REG_AW'(OFF + WIN_BASE_REL));
    assign remap_we = wr_en && (addr == REG_AW'(OFF + WIN_REMAP_REL));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (ctrl_we) ctrl_q <= word_to_ctrl(wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       base_q <= '0;
      else if (base_we) base_q <= wdata[31:16];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        remap_q <= '0;
      else if (remap_we) remap_q <= wdata[31:16];
    end

    assign win_ctrl[g]  = ctrl_q;
    assign win_base[g]  = base_q;
    assign win_remap[g] = remap_q;
  end

  // read path: next-state mux, then registered data
  logic [31:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (addr == REG_AW'(AP_CTRL_OFF)) rd_next = {ap_size_q, 15'd0, ap_en_q};
    if (addr == REG_AW'(AP_LO_OFF))   rd_next = {ap_base_q, 16'd0};
    if (addr == REG_AW'(AP_HI_OFF))   rd_next = ap_hi_q;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (addr == REG_AW'(win_off(i) + WIN_CTRL_REL))  rd_next = ctrl_to_word(win_ctrl[i]);
      if (addr == REG_AW'(win_off(i) + WIN_BASE_REL))  rd_next = {win_base[i], 16'd0};
      if (addr == REG_AW'(win_off(i) + WIN_REMAP_REL)) rd_next = {win_remap[i], 16'd0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

endmodule

// File: rtl/inb_win_match.sv
module inb_win_match
  import inb_win_pkg::*;
#(
  parameter int NUM_WIN = 6
) (
  input  logic [PAGE_W-1:0]               addr_hi,
  input  win_ctrl_t [NUM_WIN-1:0]         win_ctrl,
  input  logic [NUM_WIN-1:0][PAGE_W-1:0]  win_base,
  input  logic                            ap_en,
  input  logic [PAGE_W-1:0]               ap_size,
  input  logic [PAGE_W-1:0]               ap_base,
  input  logic [31:0]                     ap_base_hi,
  output logic [NUM_WIN-1:0]              hit_vec
);

  logic ap_hit;

  // the aperture gates every window compare
  assign ap_hit = ap_en && (ap_base_hi == 32'd0) &&
                  ((addr_hi & ~ap_size) == (ap_base & ~ap_size));

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
    logic [PAGE_W-1:0] keep;
    assign keep       = ~win_ctrl[g].size_m1;
    assign hit_vec[g] = ap_hit && win_ctrl[g].en &&
                        ((addr_hi & keep) == (win_base[g] & keep));
  end

endmodule

// File: rtl/inb_win_select.sv
module inb_win_select
  import inb_win_pkg::*;
#(
  parameter int NUM_WIN = 6
) (
  input  logic [PAGE_W-1:0]               addr_hi,
  input  logic [NUM_WIN-1:0]              hit_vec,
  input  win_ctrl_t [NUM_WIN-1:0]         win_ctrl,
  input  logic [NUM_WIN-1:0][PAGE_W-1:0]  win_remap,
  output logic                            any_hit,
  output logic [3:0]                      target,
  output logic [7:0]                      attr,
  output logic [PAGE_W-1:0]               xlat_hi
);

  localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  logic [IDX_W-1:0]  sel;
  win_ctrl_t         sel_ctrl;
  logic [PAGE_W-1:0] sel_remap;

  // descending scan: the lowest set index is the last assignment
  always_comb begin
    sel = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) sel = IDX_W'(i);
    end
  end

  assign any_hit   = |hit_vec;
  assign sel_ctrl  = win_ctrl[sel];
  assign sel_remap = win_remap[sel];
  assign target    = sel_ctrl.target;
  assign attr      = sel_ctrl.attr;

  always_comb begin
    if (sel_remap == '0) xlat_hi = addr_hi;
    else xlat_hi = (addr_hi & sel_ctrl.size_m1) | (sel_remap & ~sel_ctrl.size_m1);
  end

endmodule

// File: rtl/inb_win_decoder.sv
module inb_win_decoder
  import inb_win_pkg::*;
#(
  parameter int NUM_WIN = 6,
  parameter int REG_AW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              in_valid,
  input  logic [31:0]       in_addr,
  output logic              out_valid,
  output logic              out_hit,
  output logic              out_miss,
  output logic [3:0]        out_target,
  output logic [7:0]        out_attr,
  output logic [31:0]       out_addr
);

  win_ctrl_t [NUM_WIN-1:0]        win_ctrl;
  logic [NUM_WIN-1:0][PAGE_W-1:0] win_base;
  logic [NUM_WIN-1:0][PAGE_W-1:0] win_remap;
  logic                           ap_en;
  logic [PAGE_W-1:0]              ap_size;
  logic [PAGE_W-1:0]              ap_base;
  logic [31:0]                    ap_base_hi;
  logic [NUM_WIN-1:0]             hit_vec;
  logic                           any_hit;
  logic [3:0]                     sel_target;
  logic [7:0]                     sel_attr;
  logic [PAGE_W-1:0]              xlat_hi;

  inb_win_regs #(.NUM_WIN(NUM_WIN), .REG_AW(REG_AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr),
    .rd_en      (reg_rd),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .win_ctrl   (win_ctrl),
    .win_base   (win_base),
    .win_remap  (win_remap),
    .ap_en      (ap_en),
    .ap_size    (ap_size),
    .ap_base    (ap_base),
    .ap_base_hi (ap_base_hi)
  );

  inb_win_match #(.NUM_WIN(NUM_WIN)) u_match (
    .addr_hi    (in_addr[31:16]),
    .win_ctrl   (win_ctrl),
    .win_base   (win_base),
    .ap_en      (ap_en),
    .ap_size    (ap_size),
    .ap_base    (ap_base),
    .ap_base_hi (ap_base_hi),
    .hit_vec    (hit_vec)
  );

  inb_win_select #(.NUM_WIN(NUM_WIN)) u_sel (
    .addr_hi   (in_addr[31:16]),
    .hit_vec   (hit_vec),
    .win_ctrl  (win_ctrl),
    .win_remap (win_remap),
    .any_hit   (any_hit),
    .target    (sel_target),
    .attr      (sel_attr),
    .xlat_hi   (xlat_hi)
  );

  // result next-state
  logic        nxt_valid, nxt_hit, nxt_miss;
  logic [3:0]  nxt_target;
  logic [7:0]  nxt_attr;
  logic [31:0] nxt_addr;

  always_comb begin
    nxt_valid  = in_valid;
    nxt_hit    = in_valid && any_hit;
    nxt_miss   = in_valid && !any_hit;
    nxt_target = nxt_hit ? sel_target : 4'd0;
    nxt_attr   = nxt_hit ? sel_attr : 8'd0;
    nxt_addr   = nxt_hit ? {xlat_hi, in_addr[15:0]} : 32'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_hit    <= 1'b0;
      out_miss   <= 1'b0;
      out_target <= '0;
      out_attr   <= '0;
      out_addr   <= '0;
    end else begin
      out_valid  <= nxt_valid;
      out_hit    <= nxt_hit;
      out_miss   <= nxt_miss;
      out_target <= nxt_target;
      out_attr   <= nxt_attr;
      out_addr   <= nxt_addr;
    end
  end

endmodule

// File: rtl/inb_win_checker.sv
module inb_win_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_rd,
  input logic [31:0] reg_rdata,
  input logic        in_valid,
  input logic [15:0] in_lo,
  input logic        ap_en,
  input logic        out_valid,
  input logic        out_hit,
  input logic        out_miss,
  input logic [3:0]  out_target,
  input logic [7:0]  out_attr,
  input logic [31:0] out_addr
);

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r9_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r9_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_hit != out_miss));

  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_hit && !out_miss));

  a_r10_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_miss |-> (out_target == 4'd0 && out_attr == 8'd0 && out_addr == 32'd0));

  a_r8_low_pass: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (!out_hit || out_addr[15:0] == $past(in_lo)));

  a_r4_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ap_en) |=> out_miss);

  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));

endmodule

bind inb_win_decoder inb_win_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_rd     (reg_rd),
  .reg_rdata  (reg_rdata),
  .in_valid   (in_valid),
  .in_lo      (in_addr[15:0]),
  .ap_en      (ap_en),
  .out_valid  (out_valid),
  .out_hit    (out_hit),
  .out_miss   (out_miss),
  .out_target (out_target),
  .out_attr   (out_attr),
  .out_addr   (out_addr)
);

// File: tb/inb_win_decoder_bench.sv
`timescale 1ns/1ps
module inb_win_decoder_bench;

  localparam int NW = 6;

  logic        clk;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        in_valid;
  logic [31:0] in_addr;
  logic        out_valid, out_hit, out_miss;
  logic [3:0]  out_target;
  logic [7:0]  out_attr;
  logic [31:0] out_addr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  inb_win_decoder u_inb_win_decoder (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .in_valid(in_valid), .in_addr(in_addr),
    .out_valid(out_valid), .out_hit(out_hit), .out_miss(out_miss),
    .out_target(out_target), .out_attr(out_attr), .out_addr(out_addr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // reference state, filled in as the bench programs registers
  logic [31:0] m_ctrl  [NW];
  logic [31:0] m_base  [NW];
  logic [31:0] m_remap [NW];
  logic [31:0] m_apc, m_aplo, m_aphi;

  function automatic logic [7:0] win_off(input int i);
    return (i == NW - 1) ? 8'h80 : 8'(32'h20 + 16 * i);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic set_ap(input logic [31:0] c, input logic [31:0] lo, input logic [31:0] hi);
    wr(8'h04, c); wr(8'h10, lo); wr(8'h14, hi);
    m_apc = c; m_aplo = lo; m_aphi = hi;
  endtask

  task automatic set_win(input int i, input logic [31:0] c, input logic [31:0] b, input logic [31:0] r);
    wr(win_off(i), c); wr(win_off(i) + 8'h4, b); wr(win_off(i) + 8'hC, r);
    m_ctrl[i] = c; m_base[i] = b; m_remap[i] = r;
  endtask

  // expected {valid, hit, miss, target, attr, addr}
  function automatic logic [63:0] expect_lookup(input logic [31:0] a);
    logic [15:0] hi, sz, msz;
    logic        ap_ok, found;
    logic [3:0]  t;
    logic [7:0]  at;
    logic [31:0] oa;
    hi = a[31:16];
    sz = m_apc[31:16];
    ap_ok = m_apc[0] && (m_aphi == 32'd0) && ((hi & ~sz) == (m_aplo[31:16] & ~sz)); // R4
    found = 1'b0; t = '0; at = '0; oa = '0;
    for (int i = 0; i < NW; i++) begin
      msz = m_ctrl[i][31:16];
      if (!found && ap_ok && m_ctrl[i][0] && ((hi & ~msz) == (m_base[i][31:16] & ~msz))) begin
        found = 1'b1;                                   // R5, R6
        t  = m_ctrl[i][7:4];                            // R7
        at = m_ctrl[i][15:8];
        if (m_remap[i][31:16] == 16'd0) oa = a;         // R8
        else oa = {(hi & msz) | (m_remap[i][31:16] & ~msz), a[15:0]};
      end
    end
    return {17'd0, 1'b1, found, !found, t, at, oa};
  endfunction

  // called at a falling edge; leaves in_valid high for streaming
  task automatic look(input string req, input logic [31:0] a);
    in_valid = 1'b1; in_addr = a;
    @(negedge clk);
    check(req, {17'd0, out_valid, out_hit, out_miss, out_target, out_attr, out_addr},
          expect_lookup(a));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    in_valid = 1'b0; in_addr = '0;
    for (int i = 0; i < NW; i++) begin m_ctrl[i] = 0; m_base[i] = 0; m_remap[i] = 0; end
    m_apc = 0; m_aplo = 0; m_aphi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check("R1 out_valid after reset", {63'd0, out_valid}, 64'd0);
    rd(8'h04, d); check("R1 aperture ctrl", {32'd0, d}, 64'd0);
    rd(8'h10, d); check("R1 aperture low", {32'd0, d}, 64'd0);
    rd(8'h14, d); check("R1 aperture high", {32'd0, d}, 64'd0);
    for (int i = 0; i < NW; i++) begin
      rd(win_off(i), d);        check("R1 window ctrl", {32'd0, d}, 64'd0);
      rd(win_off(i) + 8'h4, d); check("R1 window base", {32'd0, d}, 64'd0);
      rd(win_off(i) + 8'hC, d); check("R1 window remap", {32'd0, d}, 64'd0);
    end
    @(negedge clk);
    look("R1 lookup misses", 32'h0000_0000);
    look("R1 lookup misses", 32'h1234_5678);
    in_valid = 1'b0;
    @(negedge clk);
    check("R9 idle after lookup", {61'd0, out_valid, out_hit, out_miss}, 64'd0);

    // R2, R3: field masking and register placement
    for (int i = 0; i < NW; i++) set_win(i, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    set_ap(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rd(8'h04, d); check("R2 aperture ctrl mask", {32'd0, d}, {32'd0, 32'hFFFF_0001});
    rd(8'h10, d); check("R2 aperture low mask", {32'd0, d}, {32'd0, 32'hFFFF_0000});
    rd(8'h14, d); check("R2 aperture high full", {32'd0, d}, {32'd0, 32'hFFFF_FFFF});
    for (int i = 0; i < NW; i++) begin
      rd(win_off(i), d);        check("R3 window ctrl mask", {32'd0, d}, {32'd0, 32'hFFFF_FFF1});
      rd(win_off(i) + 8'h4, d); check("R3 window base mask", {32'd0, d}, {32'd0, 32'hFFFF_0000});
      rd(win_off(i) + 8'hC, d); check("R3 window remap mask", {32'd0, d}, {32'd0, 32'hFFFF_0000});
      rd(win_off(i) + 8'h8, d); check("R3 unmapped in window", {32'd0, d}, 64'd0);
    end
    rd(8'h00, d); check("R3 unmapped 0x00", {32'd0, d}, 64'd0);
    rd(8'h08, d); check("R3 unmapped 0x08", {32'd0, d}, 64'd0);
    rd(8'h70, d); check("R3 skipped slot", {32'd0, d}, 64'd0);
    // R2: read data holds with no read strobe
    rd(8'h14, d);
    @(negedge clk); reg_addr = 8'h04;
    @(negedge clk);
    check("R2 rdata holds", {32'd0, reg_rdata}, {32'd0, 32'hFFFF_FFFF});

    // configuration one: overlapping windows, disabled window, remaps
    set_ap(32'h1FFF_0001, 32'h0000_0000, 32'h0);
    set_win(0, 32'h03FF_0E11, 32'h0000_0000, 32'h0000_0000);
    set_win(1, 32'h03FF_0D21, 32'h0400_0000, 32'h2000_0000);
    set_win(2, 32'h0FFF_3C31, 32'h0000_0000, 32'h5000_0000);
    set_win(3, 32'h0FFF_7740, 32'h1000_0000, 32'h0000_0000);
    set_win(4, 32'h00FF_4441, 32'h1000_0000, 32'h00AB_0000);
    set_win(5, 32'h00FF_AA51, 32'h1800_0000, 32'h0000_0000);
    // spot checks with values worked by hand
    @(negedge clk);
    look("R6 lowest window wins", 32'h0001_0010);
    check("R6 target of window 0", {60'd0, out_target}, 64'd1);
    look("R8 remap on window 1", 32'h0401_0022);
    check("R8 remapped address", {32'd0, out_addr}, {32'd0, 32'h2001_0022});
    look("R7 window 2 fields", 32'h0900_0001);
    check("R7 attr of window 2", {56'd0, out_attr}, {56'd0, 8'h3C});
    look("R5 disabled window ignored", 32'h1200_0000);
    check("R5 miss at disabled window", {63'd0, out_miss}, 64'd1);
    look("R8 remap inside size dropped", 32'h1034_0000);
    check("R8 window 4 address", {32'd0, out_addr}, {32'd0, 32'h0034_0000});
    look("R10 outside aperture", 32'h2000_0000);
    check("R10 zeroed outputs", {20'd0, out_target, out_attr, out_addr}, 64'd0);
    // exhaustive sweep over the page bits
    for (int k = 0; k < 65536; k++) begin
      look("R5 sweep one", {k[15:0], k[15:0] ^ 16'hA5C3});
    end
    in_valid = 1'b0;
    @(negedge clk);
    check("R9 valid drops", {63'd0, out_valid}, 64'd0);

    // configuration two: offset aperture, last window in its own slot
    for (int i = 1; i < NW - 1; i++) set_win(i, 32'h0, 32'h0, 32'h0);
    set_ap(32'h3FFF_0001, 32'h4000_0000, 32'h0);
    set_win(0, 32'h1FFF_0071, 32'h4000_0000, 32'h0001_0000);
    set_win(5, 32'h0FFF_5AF1, 32'h6000_0000, 32'h9000_0000);
    @(negedge clk);
    for (int k = 0; k < 65536; k += 7) begin
      look("R4 sweep two", {k[15:0], 16'h0F0F});
    end
    // R4: nonzero high base closes the aperture
    in_valid = 1'b0;
    set_ap(32'h3FFF_0001, 32'h4000_0000, 32'h0000_0001);
    @(negedge clk);
    look("R4 high base nonzero", 32'h4000_0000);
    look("R4 high base nonzero", 32'h6123_0000);
    check("R4 miss with high base", {63'd0, out_miss}, 64'd1);
    // R4: disabled aperture
    in_valid = 1'b0;
    set_ap(32'h3FFF_0000, 32'h4000_0000, 32'h0);
    @(negedge clk);
    look("R4 aperture disabled", 32'h4000_0000);
    look("R4 aperture disabled", 32'h6FFF_FFFF);
    check("R4 miss when disabled", {63'd0, out_miss}, 64'd1);
    in_valid = 1'b0;
    @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule